// File: doc/BRIEF.md
# Serial Converter-Code Receiver and Output Latch

This block is the receiving end of a write-only three-wire serial link that carries a 14-bit converter code. The host pulls an active-low select line down, presents one data bit per rising edge of the serial clock, most significant bit first, and releases the select line when the word is complete. A word is 16 bits long: the 14 code bits, then two trailing filler bits that the sender should leave at zero.

The serial pins are sampled by the block's own system clock. Each pin passes through a synchronizer, and edges are found by comparing successive synchronized samples. A bit counter tracks how many serial clock edges arrived while the select line was low. The output latch changes only when the select line goes high after exactly 16 edges. In that cycle the block raises a one-cycle update strobe and records whether the filler bits were nonzero. A release after any other edge count leaves the latch as it was and raises an error flag. The flag stays up until the next valid word. Reset clears the latch to code zero.

Top module: `sdac_rx_latch`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, code_o is 0 and upd_o, frame_err_o and sub_nz_o are 0, until a word is received.
- R2: Serial data is taken on each rising edge of sclk_i while cs_n_i is low. The first bit received is code bit 13 and the 14th is code bit 0.
- R3: The latch does not change when the 16th serial clock edge arrives. code_o takes the new value only after cs_n_i rises.
- R4: A word framed by exactly 16 serial clock edges produces exactly one upd_o pulse, one system clock wide, in the cycle in which code_o takes the new value.
- R5: A select-high transition after any edge count other than 16, including 0, 15 and 17 or more, leaves code_o unchanged, gives no upd_o pulse and sets frame_err_o.
- R6: frame_err_o stays high until the next valid 16-edge word. That word clears it in the same cycle as upd_o.
- R7: The 15th and 16th bits (the filler bits) never reach code_o. After each valid word, sub_nz_o is 1 if either filler bit was 1 and 0 otherwise. Invalid words leave sub_nz_o unchanged.
- R8: Serial clock edges and data seen while cs_n_i is high change neither the bit counter nor the shift register. They have no effect on code_o, upd_o or frame_err_o, and the next word is received correctly.
- R9: Each falling edge of cs_n_i restarts the bit count, so a valid word received after an invalid one is latched correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low select that frames a word |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| code_o | output | 14 | Latched converter code |
| upd_o | output | 1 | One-cycle strobe when code_o takes a new word |
| frame_err_o | output | 1 | Set by a wrongly counted word, cleared by a valid one |
| sub_nz_o | output | 1 | Filler bits of the last valid word were nonzero |

## Verification
The checker tests on every cycle that:
- code_o never changes without upd_o;
- upd_o never lasts longer than one cycle;
- frame_err_o is never high while upd_o is high;
- the bit counter and shift register hold still while select is high;
- each qualifying serial edge advances the bit counter by one.

Only the bench's scenarios can show the rest: the MSB-first bit order, that the filler bits are dropped, the edge counts that are rejected, and recovery after a bad word. The bench checks these against a model of the word format.

// File: rtl/sdac_rx_pkg.sv
// Package: shared widths for the serial converter-code receiver.
// Assumes a fixed word of code bits followed by trailing filler bits.
package sdac_rx_pkg;
    localparam int CODE_W   = 14;
    localparam int SUB_W    = 2;
    localparam int FRAME_W  = CODE_W + SUB_W;
    localparam int CNT_MAX  = FRAME_W + 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int SYNC_N   = 2;

    // Result of one select-high transition.
    typedef struct packed {
        logic             done;
        logic             ok;
        logic [FRAME_W-1:0] word;
    } frame_evt_t;
endpackage

// File: rtl/sdac_in_sync.sv
// Module: synchronizes a group of asynchronous pins and reports their edges.
// Assumes every pin is held for longer than STAGES+1 system clock periods.
module sdac_in_sync #(
    parameter int         W      = 3,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= pin_i;
                end
            end else begin : g_next
                // Pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized level for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign lvl_o  = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sdac_frame_shift.sv
// Module: shifts serial bits in and counts serial edges within one select window.
// Assumes the level, edge and data inputs come from the same synchronizer.
module sdac_frame_shift
    import sdac_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_lvl_i,
    input  logic             sel_fall_i,
    input  logic             sel_rise_i,
    input  logic             bit_edge_i,
    input  logic             bit_val_i,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [FRAME_W-1:0] shreg_o,
    output frame_evt_t       evt_o
);
    logic [CNT_W-1:0]   cnt_q, cnt_base;
    logic [FRAME_W-1:0] sr_q, sr_base;
    logic               take_bit;

    // A new window starts from an empty count and register.
    always_comb begin
        cnt_base = sel_fall_i ? '0 : cnt_q;
        sr_base  = sel_fall_i ? '0 : sr_q;
        take_bit = bit_edge_i && !sel_lvl_i;
    end

    // Advance the count and shift register on qualifying serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (take_bit) begin
            cnt_q <= (cnt_base == CNT_W'(CNT_MAX)) ? cnt_base : cnt_base + 1'b1;
            sr_q  <= {sr_base[FRAME_W-2:0], bit_val_i};
        end else if (sel_fall_i) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end
    end

    // Report the window end and whether the count was exact.
    always_comb begin
        evt_o.done = sel_rise_i;
        evt_o.ok   = (cnt_q == CNT_W'(FRAME_W));
        evt_o.word = sr_q;
    end

    assign bit_cnt_o = cnt_q;
    assign shreg_o   = sr_q;
endmodule

// File: rtl/sdac_code_latch.sv
// Module: holds the converter code and the word status flags.
// Assumes one completion event per select window.
module sdac_code_latch
    import sdac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  frame_evt_t        evt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o,
    output logic              err_o,
    output logic              sub_nz_o
);
    // Load on an exact word, flag a wrongly counted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            upd_o    <= 1'b0;
            err_o    <= 1'b0;
            sub_nz_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (evt_i.done) begin
                if (evt_i.ok) begin
                    code_o   <= evt_i.word[FRAME_W-1:SUB_W];
                    upd_o    <= 1'b1;
                    err_o    <= 1'b0;
                    sub_nz_o <= |evt_i.word[SUB_W-1:0];
                end else begin
                    err_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdac_rx_latch.sv
// Module: top of the serial converter-code receiver.
// Assumes the serial pins are slow next to clk (several clk periods per phase).
module sdac_rx_latch
    import sdac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o,
    output logic              frame_err_o,
    output logic              sub_nz_o
);
    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    frame_evt_t         evt;

    sdac_in_sync #(
        .W(3), .STAGES(SYNC_N), .RST_VAL(3'b001)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({sdata_i, sclk_i, cs_n_i}),
        .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    sdac_frame_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_lvl_i(pin_lvl[0]), .sel_fall_i(pin_fall[0]), .sel_rise_i(pin_rise[0]),
        .bit_edge_i(pin_rise[1]), .bit_val_i(pin_lvl[2]),
        .bit_cnt_o(bit_cnt), .shreg_o(shreg), .evt_o(evt)
    );

    sdac_code_latch u_latch (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .code_o(code_o), .upd_o(upd_o), .err_o(frame_err_o), .sub_nz_o(sub_nz_o)
    );
endmodule

// File: rtl/sdac_rx_latch_chk.sv
// Checker: cycle properties of the serial converter-code receiver.
module sdac_rx_latch_chk
    import sdac_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_o,
    input logic              upd_o,
    input logic              frame_err_o,
    input logic              sel_lvl,
    input logic              sel_fall,
    input logic              bit_edge,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [FRAME_W-1:0] shreg
);
    AST_CODE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> upd_o); // R3
    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R4
    AST_ERR_CLEARED_BY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> !frame_err_o); // R6
    AST_ERR_SET_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> !upd_o); // R5
    AST_IDLE_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> $stable(bit_cnt)); // R8
    AST_IDLE_SHREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> $stable(shreg)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_edge && !sel_lvl && !sel_fall && bit_cnt < CNT_W'(CNT_MAX))
        |=> (bit_cnt == $past(bit_cnt) + 1'b1)); // R2
endmodule

bind sdac_rx_latch sdac_rx_latch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .upd_o(upd_o),
    .frame_err_o(frame_err_o), .sel_lvl(pin_lvl[0]), .sel_fall(pin_fall[0]),
    .bit_edge(pin_rise[1]), .bit_cnt(bit_cnt), .shreg(shreg)
);

// File: tb/sdac_rx_latch_tb.sv
module sdac_rx_latch_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
    logic [13:0] code;
    logic upd, ferr, subnz;

    int checks = 0, failures = 0, pulses = 0;
    logic [13:0] exp_code = '0;
    logic exp_err = 1'b0, exp_sub = 1'b0;
    bit done = 1'b0;

    localparam int HOLD = 3;

    always #5 clk = ~clk;

    sdac_rx_latch u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdata_i(sdata),
        .code_o(code), .upd_o(upd), .frame_err_o(ferr), .sub_nz_o(subnz)
    );

    // Count update strobes away from the active edge.
    always @(negedge clk) if (rst_n && upd) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [13:0] model_code(input logic [15:0] w);
        return w[15:2];
    endfunction

    task automatic check_outputs(input string req);
        chk(code == exp_code, {req, " code"}, code, exp_code);
        chk(ferr == exp_err, {req, " frame_err"}, ferr, exp_err);
        chk(subnz == exp_sub, {req, " sub_nz"}, subnz, exp_sub);
    endtask

    // Send one word with a chosen number of serial clock edges.
    task automatic send(input logic [15:0] w, input int nclk, input string req);
        pulses = 0;
        cs_n = 1'b0;
        wait_clk(HOLD);
        for (int i = 0; i < nclk; i++) begin
            sdata = (i < 16) ? w[15-i] : 1'($urandom);
            wait_clk(HOLD);
            sclk = 1'b1;
            wait_clk(HOLD);
            sclk = 1'b0;
        end
        wait_clk(HOLD + 4);
        // R3: nothing moves before select is released
        chk(code == exp_code && pulses == 0, {req, " R3 hold before release"}, code, exp_code);
        cs_n = 1'b1;
        wait_clk(8);
        if (nclk == 16) begin
            exp_code = model_code(w);
            exp_err  = 1'b0;
            exp_sub  = |w[1:0];
            chk(pulses == 1, {req, " R4 one strobe"}, pulses, 1);
        end else begin
            exp_err = 1'b1;
            chk(pulses == 0, {req, " R5 no strobe"}, pulses, 0);
        end
        check_outputs(req);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_clk(4);
        check_outputs("R1 in reset");
        chk(upd == 1'b0, "R1 upd in reset", upd, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check_outputs("R1 after reset");

        send(16'hA5F0, 16, "R2 pattern");
        send(16'h8000, 16, "R2 msb only");
        send(16'h0004, 16, "R2 lsb only");
        send(16'hFFFF, 16, "R7 filler set");
        send(16'h3C01, 16, "R7 one filler");
        send(16'h1234, 15, "R5 short");
        send(16'h1234, 0, "R5 empty");
        send(16'h5678, 17, "R6 err holds long");
        send(16'h0000, 16, "R9 recover zero");
        send(16'h4321, 20, "R5 long");
        send(16'hFFFC, 16, "R6 R9 full scale");

        // R8: serial activity with select high has no effect
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            sdata = 1'($urandom);
            wait_clk(HOLD);
            sclk = 1'b1;
            wait_clk(HOLD);
            sclk = 1'b0;
        end
        wait_clk(8);
        chk(pulses == 0, "R8 no strobe while idle", pulses, 0);
        check_outputs("R8 idle clocks");
        send(16'h2AA8, 16, "R8 next word");

        for (int n = 0; n < 40; n++) begin
            int r = int'($urandom_range(0, 9));
            int nc = (r < 7) ? 16 : int'($urandom_range(0, 19));
            send(16'($urandom), nc, "R2 R5 random");
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule